// File: doc/BRIEF.md
# Effect Handler Lookup Table

This block holds the handler tower for effect dispatch. Each entry binds an effect key to a handler entry address. The key is a 4-bit family and a 4-bit op. Hardware-originated effects use family 0xF.

Entries form a stack in the order they were installed:
- An install pushes a new entry on top.
- A pop discards the newest entry.
- A lookup searches all live entries and returns the address of the newest one whose key matches.

An entry can be marked "any op". It then matches every op of its family. Boot code installs such an entry first as the outermost catch-all, so that a stray effect always reaches a fallback routine. Per-device entries installed later override it. Because the newest match wins, an "any op" entry installed later overrides older exact entries in the same way.

A lookup result (hit and address) appears one clock after the request, together with an acknowledge strobe. A full table refuses further installs and reports this with a one-cycle error pulse.

Top module: `effect_cam`

## Requirements
- R1: After reset the table is empty: every lookup misses, and `lk_ack`, `lk_hit`, `lk_addr` and `full_err` are 0.
- R2: `lk_ack` is 1 in exactly the cycles that follow a cycle with `lk_valid` high, and `lk_hit`/`lk_addr` are valid in those cycles.
- R3: An entry with `ins_any`=0 matches only when both its family and its op equal the lookup key.
- R4: An entry with `ins_any`=1 matches any op of its own family and no op of any other family.
- R5: When several live entries match, the result is the address of the most recently installed one, whether or not it is an "any op" entry.
- R6: A lookup that matches no live entry returns `lk_hit`=0 and `lk_addr`=0.
- R7: An install while DEPTH entries are live is refused and leaves the table unchanged. `full_err` is 1 in the one cycle after that request and 0 otherwise.
- R8: A pop removes the most recently installed entry. A pop on an empty table has no effect.
- R9: When `pop_valid` and `ins_valid` are both high in one cycle, the pop is performed and the install is ignored.
- R10: A lookup issued in the same cycle as an install or pop sees the table as it was before that cycle's change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Install request |
| ins_family | input | 4 | Family of the new entry |
| ins_op | input | 4 | Op of the new entry (ignored when `ins_any`=1) |
| ins_any | input | 1 | New entry matches any op of its family |
| ins_addr | input | 16 | Handler entry address of the new entry |
| pop_valid | input | 1 | Remove the newest entry |
| lk_valid | input | 1 | Lookup request |
| lk_family | input | 4 | Lookup family |
| lk_op | input | 4 | Lookup op |
| lk_ack | output | 1 | Lookup result valid (one cycle after request) |
| lk_hit | output | 1 | Lookup found a matching entry |
| lk_addr | output | 16 | Handler address of the winning entry, 0 on miss |
| full_err | output | 1 | Pulse: the previous install was refused because the table was full |

## Verification
The bench builds the block with its default parameters: 16 entries, 4-bit family and op fields, and 16-bit addresses. Sixteen entries are few enough that the bench fills the table completely. This brings the refused install and its error pulse within reach, and then the bench drains the table past empty with extra pops. The 4-bit key fields leave room for an "any op" entry to be overridden by exact entries and to override them in turn, inside a single family and next to unrelated families.

// File: rtl/effect_cam.sv
module effect_cam #(
  parameter int DEPTH = 16,
  parameter int FW    = 4,
  parameter int OW    = 4,
  parameter int AW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins_valid,
  input  logic [FW-1:0] ins_family,
  input  logic [OW-1:0] ins_op,
  input  logic          ins_any,
  input  logic [AW-1:0] ins_addr,
  input  logic          pop_valid,
  input  logic          lk_valid,
  input  logic [FW-1:0] lk_family,
  input  logic [OW-1:0] lk_op,
  output logic          lk_ack,
  output logic          lk_hit,
  output logic [AW-1:0] lk_addr,
  output logic          full_err
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [FW-1:0] fam_q [DEPTH];
  logic [OW-1:0] op_q  [DEPTH];
  logic          any_q [DEPTH];
  logic [AW-1:0] adr_q [DEPTH];
  logic [CW-1:0] cnt;

  logic is_full, is_empty, do_push, do_pop;
  assign is_full  = (cnt == CW'(DEPTH));
  assign is_empty = (cnt == '0);
  assign do_pop   = pop_valid && !is_empty;
  assign do_push  = ins_valid && !pop_valid && !is_full;

  logic          hit_c;
  logic [AW-1:0] addr_c;

  always_comb begin
    hit_c  = 1'b0;
    addr_c = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (CW'(i) < cnt && fam_q[i] == lk_family && (any_q[i] || op_q[i] == lk_op)) begin
        hit_c  = 1'b1;
        addr_c = adr_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) begin
      fam_q[IW'(cnt)] <= ins_family;
      op_q[IW'(cnt)]  <= ins_op;
      any_q[IW'(cnt)] <= ins_any;
      adr_q[IW'(cnt)] <= ins_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      lk_ack   <= 1'b0;
      lk_hit   <= 1'b0;
      lk_addr  <= '0;
      full_err <= 1'b0;
    end else begin
      if (do_pop)       cnt <= cnt - 1'b1;
      else if (do_push) cnt <= cnt + 1'b1;
      lk_ack   <= lk_valid;
      lk_hit   <= lk_valid && hit_c;
      lk_addr  <= (lk_valid && hit_c) ? addr_c : '0;
      full_err <= ins_valid && !pop_valid && is_full;
    end
  end
endmodule

module effect_cam_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5,
  parameter int AW    = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ins_valid,
  input logic          pop_valid,
  input logic          lk_valid,
  input logic          lk_ack,
  input logic          lk_hit,
  input logic [AW-1:0] lk_addr,
  input logic          full_err,
  input logic [CW-1:0] cnt
);
  // R2
  ack_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> lk_ack);
  // R2
  ack_only_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !lk_ack);
  // R6
  miss_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_ack && !lk_hit) |-> lk_addr == '0);
  // R2
  hit_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_ack);
  // R7
  full_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_err |-> ($past(cnt) == CW'(DEPTH) && $past(ins_valid) && !$past(pop_valid)));
  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  // R8
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && pop_valid) |=> cnt == '0);
  // R9
  pop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_valid && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
endmodule

bind effect_cam effect_cam_chk #(.DEPTH(DEPTH), .CW(CW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .pop_valid(pop_valid),
  .lk_valid(lk_valid), .lk_ack(lk_ack), .lk_hit(lk_hit), .lk_addr(lk_addr),
  .full_err(full_err), .cnt(cnt)
);

// File: tb/sim_effect_cam.sv
module sim_effect_cam;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic clk = 0, rst_n = 0;
  logic ins_valid = 0, ins_any = 0, pop_valid = 0, lk_valid = 0;
  logic [3:0] ins_family = 0, ins_op = 0, lk_family = 0, lk_op = 0;
  logic [15:0] ins_addr = 0;
  logic lk_ack, lk_hit, full_err;
  logic [15:0] lk_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  effect_cam u0 (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_family(ins_family),
    .ins_op(ins_op), .ins_any(ins_any), .ins_addr(ins_addr), .pop_valid(pop_valid),
    .lk_valid(lk_valid), .lk_family(lk_family), .lk_op(lk_op),
    .lk_ack(lk_ack), .lk_hit(lk_hit), .lk_addr(lk_addr), .full_err(full_err)
  );

  int checks = 0, failures = 0;
  logic [3:0]  mf [N];
  logic [3:0]  mo [N];
  logic        ma [N];
  logic [15:0] md [N];
  int mcnt = 0;

  logic        q_hit [$];
  logic [15:0] q_addr [$];
  string       q_tag [$];

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_find(input logic [3:0] f, input logic [3:0] o,
                            output logic h, output logic [15:0] a);
    h = 0; a = 0;
    for (int i = mcnt - 1; i >= 0; i--)
      if (!h && mf[i] == f && (ma[i] || mo[i] == o)) begin h = 1; a = md[i]; end
  endtask

  task automatic model_push(input logic [3:0] f, input logic [3:0] o, input logic any,
                            input logic [15:0] a);
    if (mcnt < N) begin mf[mcnt] = f; mo[mcnt] = o; ma[mcnt] = any; md[mcnt] = a; mcnt++; end
  endtask

  task automatic expect_lookup(input logic [3:0] f, input logic [3:0] o, input string tag);
    logic h; logic [15:0] a;
    model_find(f, o, h, a);
    q_hit.push_back(h); q_addr.push_back(a); q_tag.push_back(tag);
    lk_valid = 1; lk_family = f; lk_op = o;
  endtask

  task automatic tick;
    @(negedge clk);
    ins_valid = 0; pop_valid = 0; lk_valid = 0;
  endtask

  task automatic lookup(input logic [3:0] f, input logic [3:0] o, input string tag);
    expect_lookup(f, o, tag);
    tick();
  endtask

  task automatic install(input logic [3:0] f, input logic [3:0] o, input logic any,
                         input logic [15:0] a);
    ins_valid = 1; ins_family = f; ins_op = o; ins_any = any; ins_addr = a;
    model_push(f, o, any, a);
    tick();
  endtask

  task automatic pop;
    pop_valid = 1;
    if (mcnt > 0) mcnt--;
    tick();
  endtask

  always @(negedge clk) begin
    if (rst_n && lk_ack) begin
      if (q_hit.size() == 0) chk(0, "R2 unexpected ack", 1, 0);
      else begin
        logic h; logic [15:0] a; string t;
        h = q_hit.pop_front(); a = q_addr.pop_front(); t = q_tag.pop_front();
        chk(lk_hit == h, {t, " hit"}, lk_hit, h);
        chk(lk_addr == a, {t, " addr"}, lk_addr, a);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(lk_ack == 0 && lk_hit == 0 && lk_addr == 0 && full_err == 0, "R1 reset outputs",
        {lk_ack, lk_hit, full_err}, 0);
    lookup(4'hF, 4'h1, "R1 empty miss");
    tick();

    install(4'hF, 4'h0, 1, 16'h0100);
    lookup(4'hF, 4'h1, "R4 any op 1");
    lookup(4'hF, 4'h9, "R4 any op 9");
    lookup(4'hE, 4'h1, "R4 other family miss R6");

    install(4'hF, 4'h1, 0, 16'h0200);
    lookup(4'hF, 4'h1, "R5 exact over older any");
    lookup(4'hF, 4'h2, "R5 any still catches");

    install(4'h3, 4'h7, 0, 16'h0300);
    lookup(4'h3, 4'h7, "R3 exact hit");
    lookup(4'h3, 4'h6, "R3 op mismatch miss");

    install(4'hF, 4'h0, 1, 16'h0400);
    lookup(4'hF, 4'h1, "R5 newer any over exact");

    pop();
    lookup(4'hF, 4'h1, "R8 pop newest");

    // R10: lookup alongside install sees the old table
    expect_lookup(4'hF, 4'h1, "R10 lookup during install");
    ins_valid = 1; ins_family = 4'hF; ins_op = 4'h1; ins_any = 0; ins_addr = 16'h0500;
    model_push(4'hF, 4'h1, 0, 16'h0500);
    tick();
    lookup(4'hF, 4'h1, "R10 after install");

    // R9: pop and install together, install dropped
    pop_valid = 1; ins_valid = 1; ins_family = 4'hF; ins_op = 4'h1; ins_any = 0;
    ins_addr = 16'h0BAD;
    mcnt--;
    tick();
    lookup(4'hF, 4'h1, "R9 pop wins");

    for (int k = 0; mcnt < N; k++) install(4'h2, 4'(k), 0, 16'h0600 + 16'(k));
    ins_valid = 1; ins_family = 4'h2; ins_op = 4'hF; ins_any = 0; ins_addr = 16'h0FFF;
    tick();
    chk(full_err == 1, "R7 full_err pulse", full_err, 1);
    tick();
    chk(full_err == 0, "R7 full_err one cycle", full_err, 0);
    lookup(4'h2, 4'hF, "R7 refused entry absent");
    lookup(4'h2, 4'hC, "R7 last accepted entry");

    for (int k = 0; k < N + 3; k++) pop();
    chk(full_err == 0, "R8 no error on empty pops", full_err, 0);
    lookup(4'hF, 4'h1, "R8 drained miss");
    install(4'h5, 4'h5, 0, 16'h0007);
    lookup(4'h5, 4'h5, "R8 count not wrapped");
    lookup(4'h5, 4'h4, "R6 miss after refill");
    tick(); tick();
    chk(q_hit.size() == 0, "R2 all lookups acked", q_hit.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule